// File: doc/BRIEF.md
# Stacked Clear-on-Read Interrupt Status

This block holds the interrupt status of a bus-protocol controller. Eight event inputs each set their own status bit. A host reads the status word over a small register bus. The read returns the bits that are set and clears exactly those bits, so an event is never silently dropped by the read that reports its neighbours.

Each bit has one stacked pending level behind it. An event that repeats while its bit is still set, or that lands in the same cycle as a read, or that arrives while a read is settling, is parked in that pending level. A fixed number of clocks after the read strobe (parameter `PROMO_DLY`, 1 to 11), all pending bits move into the visible word at once. A host that spaces its status reads at least 12 clocks apart therefore always sees the stacked events on the next read.

A separate enable word selects which status bits drive the single interrupt line. The enable word does not gate the status bits themselves.

Top module: `irq_stack_status`

## Requirements
- R1: After a synchronous reset the status, pending and enable words, `bus_rdata` and `irq_o` are all zero.
- R2: An event pulse on `evt_i[k]` sets status bit k whether or not enable bit k is set. The bit map is: bit 7 phase mismatch or attention, bit 6 function complete, bit 5 selected, bit 4 reselected, bit 3 gross error, bit 2 unexpected disconnect, bit 1 bus reset, bit 0 parity error.
- R3: A read at address 0 (`bus_sel`=1, `bus_wr`=0) puts the status word into `bus_rdata` after the clock edge that samples the strobe. The same edge clears every bit that was returned.
- R4: If an event arrives while its status bit is set, it goes to that bit's pending level. Any number of such repeats merge into one pending bit.
- R5: If an event arrives in the same cycle as a status read, it goes to the pending level. That read neither returns it nor clears it.
- R6: Events that arrive during the settling window after a read also go to the pending level. All pending bits enter the status word together on the `PROMO_DLY`-th clock edge after the edge that sampled the read strobe. `PROMO_DLY` is less than 12.
- R7: `irq_o` is high exactly when some bit is set in both the status word and the enable word. A write at address 1 loads the enable word on that clock edge, and `irq_o` reflects the new value right after that edge. A read at address 1 returns the enable word.
- R8: A write at address 0 has no effect on the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | N_EVT | One-cycle event pulses, one per status bit |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | 0 = status, 1 = enable, others read as zero |
| bus_wdata | input | N_EVT | Write data |
| bus_rdata | output | N_EVT | Registered read data, updated only on reads |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The assertions assume that each access strobe lasts one cycle and that event inputs are single-cycle occurrences: a level held high counts as one event per cycle. They also assume that status reads are normally spaced wider than the settling window. The bench issues every read as a one-cycle pulse and lets at least 12 idle cycles pass between status reads. It deliberately puts events on the read cycle, inside the settling window and on the promotion edge, because those are the boundaries where stacking can lose or duplicate a bit.

// File: rtl/irqs_pkg.sv
package irqs_pkg;
  localparam int unsigned ADDR_W = 2;
  typedef enum logic [ADDR_W-1:0] {
    A_STAT = 2'd0,
    A_MASK = 2'd1
  } reg_addr_e;
endpackage

// File: rtl/irqs_promo_timer.sv
module irqs_promo_timer #(
  parameter int unsigned DLY = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic hold,
  output logic promote
);
  localparam int unsigned CW = $clog2(DLY + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (start)         cnt_q <= CW'(DLY);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign hold    = (cnt_q != '0);
  assign promote = (cnt_q == CW'(1));

  // R6: the window never exceeds the configured delay
  a_r6_window_range: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(DLY));
  // R6: the window only closes through a promotion cycle
  a_r6_close_by_promote: assert property (@(posedge clk) disable iff (rst)
    (hold && !start) |=> (hold || $past(promote)));
endmodule

// File: rtl/irqs_bitcell.sv
module irqs_bitcell (
  input  logic clk,
  input  logic rst,
  input  logic evt,
  input  logic rd_clr,
  input  logic hold,
  input  logic promote,
  output logic stat_d,
  output logic stat_q
);
  logic pend_q, pend_d;

  always_comb begin
    stat_d = stat_q;
    pend_d = pend_q;
    if (rd_clr) begin
      stat_d = 1'b0;
      pend_d = pend_q | evt;
    end else if (promote) begin
      stat_d = stat_q | pend_q | evt;
      pend_d = 1'b0;
    end else if (hold) begin
      pend_d = pend_q | evt;
    end else if (evt) begin
      if (stat_q) pend_d = 1'b1;
      else        stat_d = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      stat_q <= stat_d;
      pend_q <= pend_d;
    end
  end

  // R3: a status read leaves the bit clear
  a_r3_read_clears: assert property (@(posedge clk) disable iff (rst)
    rd_clr |=> !stat_q);
  // R5: an event colliding with a read is kept in the pending level
  a_r5_no_loss: assert property (@(posedge clk) disable iff (rst)
    (rd_clr && evt) |=> pend_q);
  // R2: an idle-time event is visible next cycle
  a_r2_event_sets: assert property (@(posedge clk) disable iff (rst)
    (evt && !rd_clr && !hold) |=> stat_q);
  // R4: outside a settling window nothing is pending behind a clear bit
  a_r4_pend_behind_stat: assert property (@(posedge clk) disable iff (rst)
    !hold |-> !(pend_q && !stat_q));
  // R6: the pending level is empty after promotion
  a_r6_promote_empties: assert property (@(posedge clk) disable iff (rst)
    (promote && !rd_clr) |=> !pend_q);
endmodule

// File: rtl/irqs_regport.sv
module irqs_regport
  import irqs_pkg::*;
#(
  parameter int unsigned N = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [N-1:0]      wdata,
  input  logic [N-1:0]      stat_q,
  output logic              rd_stat,
  output logic [N-1:0]      en_d,
  output logic [N-1:0]      en_q,
  output logic [N-1:0]      rdata
);
  logic wr_mask;

  assign rd_stat = sel && !wr && (addr == A_STAT);
  assign wr_mask = sel &&  wr && (addr == A_MASK);
  assign en_d    = wr_mask ? wdata : en_q;

  always_ff @(posedge clk) begin
    if (rst) en_q <= '0;
    else     en_q <= en_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (sel && !wr) begin
      case (addr)
        A_STAT:  rdata <= stat_q;
        A_MASK:  rdata <= en_q;
        default: rdata <= '0;
      endcase
    end
  end

  // R7: an enable write lands on the next edge
  a_r7_mask_write: assert property (@(posedge clk) disable iff (rst)
    (sel && wr && addr == A_MASK) |=> (en_q == $past(wdata)));
  // R3: a status read returns the pre-read status
  a_r3_read_data: assert property (@(posedge clk) disable iff (rst)
    rd_stat |=> (rdata == $past(stat_q)));
endmodule

// File: rtl/irq_stack_status.sv
module irq_stack_status
  import irqs_pkg::*;
#(
  parameter int unsigned N_EVT     = 8,
  parameter int unsigned PROMO_DLY = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_EVT-1:0]  evt_i,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [N_EVT-1:0]  bus_wdata,
  output logic [N_EVT-1:0]  bus_rdata,
  output logic              irq_o
);
  logic             rd_stat, hold, promote;
  logic [N_EVT-1:0] stat_d, stat_q, en_d, en_q;

  irqs_regport #(.N(N_EVT)) u_port (
    .clk     (clk),
    .rst     (rst),
    .sel     (bus_sel),
    .wr      (bus_wr),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .stat_q  (stat_q),
    .rd_stat (rd_stat),
    .en_d    (en_d),
    .en_q    (en_q),
    .rdata   (bus_rdata)
  );

  irqs_promo_timer #(.DLY(PROMO_DLY)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .start   (rd_stat),
    .hold    (hold),
    .promote (promote)
  );

  for (genvar k = 0; k < N_EVT; k++) begin : g_bit
    irqs_bitcell u_cell (
      .clk     (clk),
      .rst     (rst),
      .evt     (evt_i[k]),
      .rd_clr  (rd_stat),
      .hold    (hold),
      .promote (promote),
      .stat_d  (stat_d[k]),
      .stat_q  (stat_q[k])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= |(stat_d & en_d);
  end

  // R7: the registered line tracks status and enable registers
  a_r7_irq_match: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (irq_o == |(stat_q & en_q)));
  // R8: a status write leaves the status word alone when nothing else acts
  a_r8_stat_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_wr && bus_addr == A_STAT && evt_i == '0 && !hold)
      |=> (stat_q == $past(stat_q)));
endmodule

// File: tb/test_irq_stack_status.sv
module test_irq_stack_status;
  localparam int N = 8;
  localparam int D = 4;

  logic         clk = 1'b0;
  logic         rst;
  logic [N-1:0] evt_i;
  logic         bus_sel, bus_wr;
  logic [1:0]   bus_addr;
  logic [N-1:0] bus_wdata;
  logic [N-1:0] bus_rdata;
  logic         irq_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // behavioural reference state
  logic [N-1:0] m_stat, m_pend, m_en, m_rdata;
  int           m_left;

  always #2.5 clk = ~clk;

  irq_stack_status #(.N_EVT(N), .PROMO_DLY(D)) i_irq_stack_status (
    .clk(clk), .rst(rst), .evt_i(evt_i), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input string what, input logic [N-1:0] act,
                     input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic [N-1:0] ev, input logic s, input logic w,
                      input logic [1:0] a, input logic [N-1:0] wd, input string tag);
    bit is_rd;
    evt_i = ev; bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = wd;
    is_rd = s && !w;
    if (is_rd) m_rdata = (a == 2'd0) ? m_stat : (a == 2'd1) ? m_en : '0;
    if (is_rd && a == 2'd0) begin
      m_stat = '0;
      m_pend = m_pend | ev;
      m_left = D;
    end else if (m_left == 1) begin
      m_stat = m_stat | m_pend | ev;
      m_pend = '0;
      m_left = 0;
    end else if (m_left > 0) begin
      m_pend = m_pend | ev;
      m_left--;
    end else begin
      m_pend = m_pend | (ev & m_stat);
      m_stat = m_stat | ev;
    end
    if (s && w && a == 2'd1) m_en = wd;
    @(posedge clk);
    #1;
    chk(tag, "irq_o", {{(N-1){1'b0}}, irq_o}, {{(N-1){1'b0}}, |(m_stat & m_en)});
    chk(tag, "bus_rdata", bus_rdata, m_rdata);
    evt_i = '0; bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step('0, 1'b0, 1'b0, 2'd0, '0, tag);
  endtask

  task automatic rd_stat(input logic [N-1:0] ev, input logic [N-1:0] exp, input string tag);
    step(ev, 1'b1, 1'b0, 2'd0, '0, tag);
    chk(tag, "status literal", bus_rdata, exp);
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [N-1:0] d, input string tag);
    step('0, 1'b1, 1'b1, a, d, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; evt_i = '0; bus_sel = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
    m_stat = '0; m_pend = '0; m_en = '0; m_rdata = '0; m_left = 0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    chk("R1", "rdata after reset", bus_rdata, '0);
    chk("R1", "irq after reset", {7'd0, irq_o}, '0);
    step('0, 1'b1, 1'b0, 2'd1, '0, "R1");
    chk("R1", "enable after reset", bus_rdata, 8'h00);
    idle(2, "R1");
    rd_stat('0, 8'h00, "R1");
    idle(12, "R1");

    // R2: event with enable clear still sets status, irq stays low
    step(8'h08, 0, 0, 0, '0, "R2");
    idle(2, "R2");
    rd_stat('0, 8'h08, "R2");
    idle(12, "R3");
    rd_stat('0, 8'h00, "R3");
    idle(12, "R3");

    // R7: enable writes and read-back, irq follows
    wr_reg(2'd1, 8'hFF, "R7");
    step('0, 1'b1, 1'b0, 2'd1, '0, "R7");
    chk("R7", "enable read", bus_rdata, 8'hFF);
    step(8'h01, 0, 0, 0, '0, "R7");
    chk("R7", "irq after event", {7'd0, irq_o}, 8'h01);
    wr_reg(2'd1, 8'h00, "R7");
    chk("R7", "irq masked next clock", {7'd0, irq_o}, 8'h00);
    wr_reg(2'd1, 8'hFF, "R7");
    idle(1, "R7");
    rd_stat('0, 8'h01, "R7");
    idle(12, "R7");

    // R4: repeated events merge into one pending level
    step(8'h20, 0, 0, 0, '0, "R4");
    step(8'h20, 0, 0, 0, '0, "R4");
    step(8'h24, 0, 0, 0, '0, "R4");
    rd_stat('0, 8'h24, "R4");
    idle(12, "R4");
    rd_stat('0, 8'h20, "R4");
    idle(12, "R4");
    rd_stat('0, 8'h00, "R4");
    idle(12, "R4");

    // R5: event in the read cycle is stacked, not returned
    step(8'h80, 0, 0, 0, '0, "R5");
    rd_stat(8'h82, 8'h80, "R5");
    idle(12, "R5");
    rd_stat('0, 8'h82, "R5");
    idle(12, "R5");

    // R6: promotion timing, events in window and on the promote edge
    wr_reg(2'd1, 8'h10, "R6");
    step(8'h01, 0, 0, 0, '0, "R6");
    rd_stat('0, 8'h01, "R6");
    step(8'h10, 0, 0, 0, '0, "R6");
    for (int i = 0; i < D - 2; i++) begin
      step('0, 0, 0, 0, '0, "R6");
      chk("R6", "irq low in window", {7'd0, irq_o}, 8'h00);
    end
    step(8'h40, 0, 0, 0, '0, "R6");
    chk("R6", "irq on promote edge", {7'd0, irq_o}, 8'h01);
    idle(12, "R6");
    rd_stat('0, 8'h50, "R6");
    idle(12, "R6");

    // R8: status writes ignored
    step(8'h04, 0, 0, 0, '0, "R8");
    wr_reg(2'd0, 8'hFF, "R8");
    wr_reg(2'd0, 8'h00, "R8");
    rd_stat('0, 8'h04, "R8");
    idle(12, "R8");
    step('0, 1'b1, 1'b0, 2'd3, '0, "R8");
    chk("R8", "unmapped read", bus_rdata, 8'h00);
    idle(12, "R8");

    // all events at once, both layers
    step(8'hFF, 0, 0, 0, '0, "R2");
    step(8'hFF, 0, 0, 0, '0, "R4");
    rd_stat(8'h00, 8'hFF, "R4");
    idle(12, "R6");
    rd_stat('0, 8'hFF, "R6");
    idle(12, "R6");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule